// File: doc/BRIEF.md
# Port Change Interrupt Generator

This block watches a 16-bit general-purpose port and raises an active-low interrupt whenever a pin in input mode has a level that differs from the value last captured for it. The captured values form a 16-bit snapshot. The register file returns this snapshot when the host reads either input byte, so the snapshot is the input register the host sees.

The interrupt goes away in two ways. The first is when the pins return to their captured levels, which needs no bus access. The second is when the host reads the byte that holds the change. The bus engine marks the acknowledge clock of that read data byte with a one-cycle strobe and a byte select. On that edge the selected snapshot byte reloads from the pins, and only that byte.

Pins in output mode are masked and cannot request an interrupt. When a pin turns from output to input, it requests an interrupt at once if its level differs from its snapshot bit. Pin synchronization, the serial engine and the open-drain pad sit outside this block.

Top module: `pin_change_irq`

## Requirements
- R1: When an input-mode pin differs from its snapshot bit and no read clear is active, `irq_n_o` is low after the next rising clock edge. The response is exactly one cycle later, so the output does not change before that edge.
- R2: A pin whose `dir_in_i` bit is 0 (output mode) never pulls `irq_n_o` low, whatever its level.
- R3: When every input-mode pin matches its snapshot bit, `irq_n_o` is high after the next edge. No read clear is needed for this.
- R4: On an edge where `rd_clr_i` is 1, snapshot byte `rd_sel_i` loads from the pins on that same edge. Select 0 covers bits 7:0 and select 1 covers bits 15:8. If the other byte has no pending difference, `irq_n_o` is high from that edge on.
- R5: A read clear leaves the unselected snapshot byte unchanged, so a pending difference in the other byte keeps `irq_n_o` low. With no read clear, the whole snapshot holds its value.
- R6: A pin change that comes after a read clear pulls `irq_n_o` low again.
- R7: Changing a pin's `dir_in_i` bit from 0 to 1 while its level differs from its snapshot bit pulls `irq_n_o` low after the next edge.
- R8: While `rst_n` is low at a clock edge, the snapshot loads from the pins and `irq_n_o` is high. After reset, `snap_o` shows the pin values that were present during reset.
- R9: A pin change that lands in the same cycle as the read clear of its byte goes into the snapshot and raises no interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pins_i | input | 16 | Synchronized pin levels |
| dir_in_i | input | 16 | Direction per pin, 1 = input mode |
| rd_clr_i | input | 1 | One-cycle strobe at the acknowledge clock of a port read |
| rd_sel_i | input | 1 | Byte being read: 0 = bits 7:0, 1 = bits 15:8 |
| irq_n_o | output | 1 | Interrupt, active low, registered |
| snap_o | output | 16 | Captured input snapshot |

## Verification
Single-pin toggles on input pins, followed by a return to the old level, show that the interrupt follows the level difference and not an edge. The same kind of toggle on output-mode pins, followed by flipping the direction, separates masking from detection. Changes spread across both bytes, each cleared by its own byte read, expose any clear that touches the wrong byte. A change placed in the same cycle as the clear strobe shows that a change during the acknowledge clock is absorbed.

// File: rtl/pcirq_pkg.sv
package pcirq_pkg;
   localparam int unsigned DEF_BYTE_W    = 8;
   localparam int unsigned DEF_NUM_BYTES = 2;

   function automatic int unsigned sel_width(input int unsigned n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction
endpackage

// File: rtl/pcirq_snap_byte.sv
module pcirq_snap_byte #(
   parameter int unsigned BYTE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_i,
   input  logic [BYTE_W-1:0] pins_i,
   output logic [BYTE_W-1:0] snap_q,
   output logic [BYTE_W-1:0] snap_next
);
   always_ff @(posedge clk) begin
      if (!rst_n || load_i)
         snap_q <= pins_i;
   end

   // Value the snapshot holds after this edge; used so that a clear acts at once
   assign snap_next = load_i ? pins_i : snap_q;
endmodule

// File: rtl/pcirq_byte_diff.sv
module pcirq_byte_diff #(
   parameter int unsigned BYTE_W = 8
) (
   input  logic [BYTE_W-1:0] pins_i,
   input  logic [BYTE_W-1:0] ref_i,
   input  logic [BYTE_W-1:0] dir_in_i,
   output logic              any_o
);
   logic [BYTE_W-1:0] masked;

   assign masked = (pins_i ^ ref_i) & dir_in_i;
   assign any_o  = |masked;
endmodule

// File: rtl/pin_change_irq.sv
module pin_change_irq
   import pcirq_pkg::*;
#(
   parameter int unsigned BYTE_W    = DEF_BYTE_W,
   parameter int unsigned NUM_BYTES = DEF_NUM_BYTES,
   localparam int unsigned PORT_W   = BYTE_W * NUM_BYTES,
   localparam int unsigned SEL_W    = sel_width(NUM_BYTES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [PORT_W-1:0] pins_i,
   input  logic [PORT_W-1:0] dir_in_i,
   input  logic              rd_clr_i,
   input  logic [SEL_W-1:0]  rd_sel_i,
   output logic              irq_n_o,
   output logic [PORT_W-1:0] snap_o
);
   if (BYTE_W < 1) begin : g_bad_byte_w
      $error("pin_change_irq: BYTE_W must be at least 1");
   end
   if (NUM_BYTES < 1) begin : g_bad_num_bytes
      $error("pin_change_irq: NUM_BYTES must be at least 1");
   end

   logic [NUM_BYTES-1:0] byte_pend;
   logic [NUM_BYTES-1:0] byte_load;
   logic                 irq_q;

   for (genvar b = 0; b < NUM_BYTES; b++) begin : g_byte
      logic [BYTE_W-1:0] nxt;

      if (NUM_BYTES == 1) begin : g_single
         assign byte_load[b] = rd_clr_i;
      end else begin : g_multi
         assign byte_load[b] = rd_clr_i && (rd_sel_i == SEL_W'(b));
      end

      pcirq_snap_byte #(.BYTE_W(BYTE_W)) u_snap (
         .clk      (clk),
         .rst_n    (rst_n),
         .load_i   (byte_load[b]),
         .pins_i   (pins_i[b*BYTE_W +: BYTE_W]),
         .snap_q   (snap_o[b*BYTE_W +: BYTE_W]),
         .snap_next(nxt)
      );

      pcirq_byte_diff #(.BYTE_W(BYTE_W)) u_diff (
         .pins_i  (pins_i[b*BYTE_W +: BYTE_W]),
         .ref_i   (nxt),
         .dir_in_i(dir_in_i[b*BYTE_W +: BYTE_W]),
         .any_o   (byte_pend[b])
      );
   end

   always_ff @(posedge clk) begin
      if (!rst_n) irq_q <= 1'b0;
      else        irq_q <= |byte_pend;
   end

   assign irq_n_o = ~irq_q;
endmodule

// File: rtl/pin_change_irq_chk.sv
module pin_change_irq_chk #(
   parameter int unsigned BYTE_W    = 8,
   parameter int unsigned NUM_BYTES = 2,
   parameter int unsigned PORT_W    = 16,
   parameter int unsigned SEL_W     = 1
) (
   input logic              clk,
   input logic              rst_n,
   input logic [PORT_W-1:0] pins_i,
   input logic [PORT_W-1:0] dir_in_i,
   input logic              rd_clr_i,
   input logic [SEL_W-1:0]  rd_sel_i,
   input logic              irq_n_o,
   input logic [PORT_W-1:0] snap_o
);
   assert_raise_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (!rd_clr_i && (((pins_i ^ snap_o) & dir_in_i) != '0)) |=> !irq_n_o);

   assert_out_mask_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (dir_in_i == '0) |=> irq_n_o);

   assert_return_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (((pins_i ^ snap_o) & dir_in_i) == '0) |=> irq_n_o);

   assert_clear_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
      rd_clr_i |=> (snap_o[$past(rd_sel_i)*BYTE_W +: BYTE_W]
                    == $past(pins_i[rd_sel_i*BYTE_W +: BYTE_W])));

   assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_clr_i |=> $stable(snap_o));
endmodule

bind pin_change_irq pin_change_irq_chk #(
   .BYTE_W(BYTE_W), .NUM_BYTES(NUM_BYTES), .PORT_W(PORT_W), .SEL_W(SEL_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .pins_i(pins_i), .dir_in_i(dir_in_i),
   .rd_clr_i(rd_clr_i), .rd_sel_i(rd_sel_i), .irq_n_o(irq_n_o), .snap_o(snap_o)
);

// File: tb/pin_change_irq_tb_top.sv
module pin_change_irq_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] pins = 16'hA5C3;
   logic [15:0] dir = 16'hFFFF;
   logic        rd_clr = 1'b0;
   logic [0:0]  rd_sel = 1'b0;
   logic        irq_n;
   logic [15:0] snap;
   int          n_chk = 0;
   int          n_err = 0;
   bit          done = 1'b0;

   always #2 clk = ~clk;

   pin_change_irq dut_i (
      .clk(clk), .rst_n(rst_n), .pins_i(pins), .dir_in_i(dir),
      .rd_clr_i(rd_clr), .rd_sel_i(rd_sel), .irq_n_o(irq_n), .snap_o(snap)
   );

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic t_reset();
      rst_n = 1'b0; step(); step();
      rst_n = 1'b1;
      chk("R8 irq after reset", {15'd0, irq_n}, 16'd1);
      chk("R8 snapshot after reset", snap, 16'hA5C3);
   endtask

   task automatic t_change_return();
      pins = 16'hA5CB;
      chk("R1 no early response", {15'd0, irq_n}, 16'd1);
      step();
      chk("R1 raise on bit3", {15'd0, irq_n}, 16'd0);
      pins = 16'hA5C3; step();
      chk("R3 return clears", {15'd0, irq_n}, 16'd1);
   endtask

   task automatic t_mask_dir();
      dir = 16'hFF00; pins = 16'hA5C2; step();
      chk("R2 output pin masked", {15'd0, irq_n}, 16'd1);
      dir = 16'hFFFF; step();
      chk("R7 output to input mismatch", {15'd0, irq_n}, 16'd0);
      rd_clr = 1'b1; rd_sel = 1'b0; step();
      rd_clr = 1'b0;
      chk("R4 read clear byte0 irq", {15'd0, irq_n}, 16'd1);
      chk("R4 read clear byte0 snap", snap, 16'hA5C2);
   endtask

   task automatic t_partial();
      pins = 16'hA7C6; step();
      chk("R1 two-byte change", {15'd0, irq_n}, 16'd0);
      rd_clr = 1'b1; rd_sel = 1'b0; step();
      chk("R5 other byte keeps irq", {15'd0, irq_n}, 16'd0);
      chk("R5 high byte untouched", snap, 16'hA5C6);
      rd_sel = 1'b1; step();
      rd_clr = 1'b0;
      chk("R4 read clear byte1 irq", {15'd0, irq_n}, 16'd1);
      chk("R4 read clear byte1 snap", snap, 16'hA7C6);
   endtask

   task automatic t_recheck();
      pins = 16'h27C6; step();
      chk("R6 change after clear", {15'd0, irq_n}, 16'd0);
      pins = 16'hA7C6; step();
      chk("R3 back to snapshot", {15'd0, irq_n}, 16'd1);
   endtask

   task automatic t_absorb();
      pins = 16'hA7D6; rd_clr = 1'b1; rd_sel = 1'b0; step();
      rd_clr = 1'b0;
      chk("R9 change absorbed irq", {15'd0, irq_n}, 16'd1);
      chk("R9 change absorbed snap", snap, 16'hA7D6);
      step();
      chk("R9 stays quiet", {15'd0, irq_n}, 16'd1);
   endtask

   initial begin
      @(negedge clk);
      t_reset();
      t_change_return();
      t_mask_dir();
      t_partial();
      t_recheck();
      t_absorb();
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (5000) @(posedge clk);
            n_chk++; n_err++;
            $display("FAIL watchdog: actual=timeout expected=done");
         end
      join_any
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule